// File: doc/BRIEF.md
# Programmable Chip-Select Area Decoder

This block compares each bus address with eight programmable memory areas. It drives one chip-select line for the area that claims the address. It also passes that area's data width and byte order to the bus sequencer, which generates the external access. Each area has a window and an attribute set. The window is a base and a size mask at 64 KB granularity. The attributes are an enable, a width code, a byte-order bit and a read-only bit. Software programs both through a simple register-write port.

For each request strobe the block produces registered results one clock later. These are a one-hot chip-select vector, a hit flag, a miss flag, and the winning area's width and endianness. If more than one enabled area matches, the lowest-numbered area takes the access. A write aimed at a read-only area selects nothing and latches a fault flag. That flag stays set until the next register write.

Top module: `cs_area_decoder`

## Requirements
- R1: For a request, at most one chip-select bit is set, one clock after `req_i` is sampled. `hit_o` equals "some chip select is set". Bit i of `cs_o` belongs to area i.
- R2: An area spans (mask+1) blocks of 64 KB. The mask is written in `cfg_wdata_i[15:0]` of a window write (`cfg_kind_i`=0). Mask bit 15 is ignored, which caps the area at 2 GB.
- R3: An address hits an area when the upper address bits equal the base (`cfg_wdata_i[31:16]` of a window write) in every position the mask leaves clear. Base bits under the mask have no effect, so every area is aligned to its own size.
- R4: An area whose enable bit is clear (`cfg_wdata_i[0]` of an attribute write, `cfg_kind_i`=1) never asserts its chip select.
- R5: A write (`wr_i`=1) whose winning area has the read-only bit (`cfg_wdata_i[4]`) set asserts no chip select, no hit and no miss. A read of the same area is served normally.
- R6: On a hit, `width_o` shows the area's width code from `cfg_wdata_i[2:1]`: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit. Code 3 is stored as 2. `big_endian_o` shows `cfg_wdata_i[3]`. Both outputs are 0 when there is no hit.
- R7: Area 0 always reports big-endian, whatever its attribute write holds.
- R8: When enabled areas overlap, the lowest-numbered matching enabled area wins. A read-only winner blocks a write outright; the write does not pass to the next area.
- R9: `fault_o` is set by a blocked write and stays set across later accesses. Any register write clears it, unless a blocked write occurs in the same cycle.
- R10: After reset every output is 0. Area 0 is enabled as a 32-bit, big-endian area covering the top 64 KB (base 0xFFFF, mask 0). All other areas are disabled.
- R11: A request that hits no enabled area gives `miss_o`=1 for exactly one cycle and no chip select. Without a request, `cs_o`, `hit_o` and `miss_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request strobe |
| wr_i | input | 1 | 1 = write access, 0 = read |
| addr_i | input | 32 | Byte address of the access |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_kind_i | input | 1 | 0 = window write, 1 = attribute write |
| cfg_sel_i | input | 3 | Area being programmed |
| cfg_wdata_i | input | 32 | Register write data |
| cs_o | output | 8 | One-hot chip selects |
| hit_o | output | 1 | Access claimed by an area |
| miss_o | output | 1 | Request matched no enabled area |
| width_o | output | 2 | Width code of the selected area |
| big_endian_o | output | 1 | Byte order of the selected area |
| fault_o | output | 1 | Sticky write-protect fault |

## Verification
The assertions rely on two conditions. Register writes and requests are driven only while reset is low. `req_i` and `wr_i` are held at 0 during reset, so the first post-reset comparisons with the previous cycle are meaningful. The properties on the fault flag also assume that a rising fault comes only from a request presented in the previous cycle. The bench keeps to this by never asserting a request and a register write in the same cycle. Every mask it programs is a run of low ones, so each window is a true power-of-two, size-aligned region.

// File: rtl/cs_area_pkg.sv
package cs_area_pkg;

  localparam logic [1:0] WCODE_8  = 2'd0;
  localparam logic [1:0] WCODE_16 = 2'd1;
  localparam logic [1:0] WCODE_32 = 2'd2;

  typedef struct packed {
    logic       ro;
    logic       big_end;
    logic [1:0] width;
    logic       en;
  } area_attr_t;

  localparam int ATTR_BITS = $bits(area_attr_t);

endpackage

// File: rtl/cs_area_regs.sv
module cs_area_regs
  import cs_area_pkg::*;
#(
  parameter int N_AREAS = 8,
  parameter int BLK_W   = 16,
  localparam int SEL_W  = $clog2(N_AREAS),
  localparam int CFG_W  = 2 * BLK_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we_i,
  input  logic                               cfg_kind_i,
  input  logic [SEL_W-1:0]                   cfg_sel_i,
  input  logic [CFG_W-1:0]                   cfg_wdata_i,
  output logic [N_AREAS-1:0][BLK_W-1:0]      base_o,
  output logic [N_AREAS-1:0][BLK_W-1:0]      mask_o,
  output area_attr_t [N_AREAS-1:0]           attr_o
);

  logic [BLK_W-1:0] wr_base;
  logic [BLK_W-1:0] wr_mask;
  area_attr_t       wr_attr;
  logic             unused_cfg;

  assign wr_base = cfg_wdata_i[CFG_W-1:BLK_W];
  // top mask bit dropped: an area never exceeds half the space
  assign wr_mask = {1'b0, cfg_wdata_i[BLK_W-2:0]};
  assign unused_cfg = ^{cfg_wdata_i[CFG_W-1:ATTR_BITS], cfg_wdata_i[BLK_W-1]};

  always_comb begin
    wr_attr.en      = cfg_wdata_i[0];
    wr_attr.width   = (cfg_wdata_i[2:1] == 2'd3) ? WCODE_32 : cfg_wdata_i[2:1];
    wr_attr.big_end = cfg_wdata_i[3];
    wr_attr.ro      = cfg_wdata_i[4];
  end

  for (genvar i = 0; i < N_AREAS; i++) begin : g_area
    logic hit_sel;
    assign hit_sel = cfg_we_i && (cfg_sel_i == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[i] <= (i == 0) ? '1 : '0;
        mask_o[i] <= '0;
      end else if (hit_sel && !cfg_kind_i) begin
        base_o[i] <= wr_base;
        mask_o[i] <= wr_mask;
      end
    end

    if (i == 0) begin : g_fixed_order
      always_ff @(posedge clk) begin
        if (rst) begin
          attr_o[i] <= '{ro: 1'b0, big_end: 1'b1, width: WCODE_32, en: 1'b1};
        end else if (hit_sel && cfg_kind_i) begin
          attr_o[i] <= '{ro: wr_attr.ro, big_end: 1'b1, width: wr_attr.width,
                         en: wr_attr.en};
        end
      end
    end else begin : g_free_order
      always_ff @(posedge clk) begin
        if (rst) begin
          attr_o[i] <= '0;
        end else if (hit_sel && cfg_kind_i) begin
          attr_o[i] <= wr_attr;
        end
      end
    end
  end

endmodule

// File: rtl/cs_area_match.sv
module cs_area_match
  import cs_area_pkg::*;
#(
  parameter int N_AREAS = 8,
  parameter int BLK_W   = 16
) (
  input  logic [BLK_W-1:0]               blk_i,
  input  logic [N_AREAS-1:0][BLK_W-1:0]  base_i,
  input  logic [N_AREAS-1:0][BLK_W-1:0]  mask_i,
  input  area_attr_t [N_AREAS-1:0]       attr_i,
  output logic [N_AREAS-1:0]             match_o
);

  for (genvar i = 0; i < N_AREAS; i++) begin : g_cmp
    logic [BLK_W-1:0] diff;
    assign diff       = (blk_i ^ base_i[i]) & ~mask_i[i];
    assign match_o[i] = attr_i[i].en && (diff == '0);
  end

endmodule

// File: rtl/cs_area_prio.sv
module cs_area_prio #(
  parameter int N_AREAS = 8,
  localparam int SEL_W  = $clog2(N_AREAS)
) (
  input  logic [N_AREAS-1:0] match_i,
  output logic [N_AREAS-1:0] grant_o,
  output logic [SEL_W-1:0]   idx_o,
  output logic               any_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N_AREAS - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = SEL_W'(i);
    end
    any_o   = |match_i;
    grant_o = any_o ? (N_AREAS'(1) << idx_o) : '0;
  end

endmodule

// File: rtl/cs_area_decoder.sv
module cs_area_decoder
  import cs_area_pkg::*;
#(
  parameter int N_AREAS   = 8,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 16,
  localparam int BLK_W    = ADDR_W - GRAN_BITS,
  localparam int SEL_W    = $clog2(N_AREAS),
  localparam int CFG_W    = 2 * BLK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               cfg_we_i,
  input  logic               cfg_kind_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [N_AREAS-1:0] cs_o,
  output logic               hit_o,
  output logic               miss_o,
  output logic [1:0]         width_o,
  output logic               big_endian_o,
  output logic               fault_o
);

  logic [N_AREAS-1:0][BLK_W-1:0] base;
  logic [N_AREAS-1:0][BLK_W-1:0] mask;
  area_attr_t [N_AREAS-1:0]      attr;
  logic [N_AREAS-1:0]            match;
  logic [N_AREAS-1:0]            grant;
  logic [SEL_W-1:0]              win_idx;
  logic                          any_match;
  area_attr_t                    win_attr;
  logic                          blocked;
  logic                          take;
  logic                          unused_low;

  assign unused_low = ^addr_i[GRAN_BITS-1:0];

  cs_area_regs #(.N_AREAS(N_AREAS), .BLK_W(BLK_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cfg_we_i    (cfg_we_i),
    .cfg_kind_i  (cfg_kind_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .base_o      (base),
    .mask_o      (mask),
    .attr_o      (attr)
  );

  cs_area_match #(.N_AREAS(N_AREAS), .BLK_W(BLK_W)) u_match (
    .blk_i   (addr_i[ADDR_W-1:GRAN_BITS]),
    .base_i  (base),
    .mask_i  (mask),
    .attr_i  (attr),
    .match_o (match)
  );

  cs_area_prio #(.N_AREAS(N_AREAS)) u_prio (
    .match_i (match),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_match)
  );

  assign win_attr = attr[win_idx];
  assign blocked  = req_i && any_match && wr_i && win_attr.ro;
  assign take     = req_i && any_match && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o         <= '0;
      hit_o        <= 1'b0;
      miss_o       <= 1'b0;
      width_o      <= '0;
      big_endian_o <= 1'b0;
      fault_o      <= 1'b0;
    end else begin
      cs_o         <= take ? grant : '0;
      hit_o        <= take;
      miss_o       <= req_i && !any_match;
      width_o      <= take ? win_attr.width : '0;
      big_endian_o <= take && win_attr.big_end;
      if (blocked)       fault_o <= 1'b1;
      else if (cfg_we_i) fault_o <= 1'b0;
    end
  end

endmodule

// File: rtl/cs_area_decoder_chk.sv
module cs_area_decoder_chk #(
  parameter int N_AREAS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               req_i,
  input logic               wr_i,
  input logic               cfg_we_i,
  input logic [N_AREAS-1:0] cs_o,
  input logic               hit_o,
  input logic               miss_o,
  input logic [1:0]         width_o,
  input logic               big_endian_o,
  input logic               fault_o
);

  a_r1_onehot_cs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o));

  a_r1_hit_tracks_cs: assert property (@(posedge clk) disable iff (rst)
    hit_o == (cs_o != '0));

  a_r11_hit_miss_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hit_o && miss_o));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(req_i) |-> (cs_o == '0 && !miss_o));

  a_r5_fault_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> ($past(req_i && wr_i) && cs_o == '0 && !hit_o));

  a_r9_fault_clear_by_cfg: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_o) |-> $past(cfg_we_i));

  a_r7_area0_big_endian: assert property (@(posedge clk) disable iff (rst)
    cs_o[0] |-> big_endian_o);

  a_r6_width_legal: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (width_o != 2'b11));

endmodule

bind cs_area_decoder cs_area_decoder_chk #(.N_AREAS(N_AREAS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_i        (req_i),
  .wr_i         (wr_i),
  .cfg_we_i     (cfg_we_i),
  .cs_o         (cs_o),
  .hit_o        (hit_o),
  .miss_o       (miss_o),
  .width_o      (width_o),
  .big_endian_o (big_endian_o),
  .fault_o      (fault_o)
);

// File: tb/cs_area_decoder_test.sv
`timescale 1ns/1ps
module cs_area_decoder_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_i, wr_i, cfg_we_i, cfg_kind_i;
  logic [31:0] addr_i;
  logic [2:0]  cfg_sel_i;
  logic [31:0] cfg_wdata_i;
  logic [7:0]  cs_o;
  logic        hit_o, miss_o, big_endian_o, fault_o;
  logic [1:0]  width_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cs_area_decoder uut (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .cfg_we_i(cfg_we_i), .cfg_kind_i(cfg_kind_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .cs_o(cs_o), .hit_o(hit_o), .miss_o(miss_o),
    .width_o(width_o), .big_endian_o(big_endian_o), .fault_o(fault_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic [7:0] cs, input logic hit,
                            input logic miss, input logic [1:0] w, input logic be);
    check({tag, " cs"},    {24'd0, cs_o},        {24'd0, cs});
    check({tag, " hit"},   {31'd0, hit_o},       {31'd0, hit});
    check({tag, " miss"},  {31'd0, miss_o},      {31'd0, miss});
    check({tag, " width"}, {30'd0, width_o},     {30'd0, w});
    check({tag, " endian"},{31'd0, big_endian_o},{31'd0, be});
  endtask

  task automatic cfg(input logic kind, input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_kind_i = kind; cfg_sel_i = sel; cfg_wdata_i = data;
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [31:0] addr);
    @(negedge clk);
    req_i = 1'b1; wr_i = wr; addr_i = addr;
    @(posedge clk); #1;
    req_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 fault after reset", {31'd0, fault_o}, 32'd0);
    expect_out("R10 idle after reset", 8'h00, 0, 0, 2'd0, 0);
    access(0, 32'hFFFF_1234);
    expect_out("R10 area0 top block", 8'h01, 1, 0, 2'd2, 1);
    access(0, 32'h0000_1000);
    expect_out("R11 miss", 8'h00, 0, 1, 2'd0, 0);
    @(posedge clk); #1;
    expect_out("R11 no request", 8'h00, 0, 0, 2'd0, 0);
  endtask

  task automatic t_window;
    cfg(0, 3'd1, 32'h1000_000F);
    cfg(1, 3'd1, 32'h03);
    access(0, 32'h100F_FFFC);
    expect_out("R2 1MB area last word", 8'h02, 1, 0, 2'd1, 0);
    access(0, 32'h1010_0000);
    expect_out("R2 past area end", 8'h00, 0, 1, 2'd0, 0);
    cfg(0, 3'd2, 32'h8000_FFFF);
    cfg(1, 3'd2, 32'h0D);
    access(1, 32'h8000_0000);
    expect_out("R2 2GB area write", 8'h04, 1, 0, 2'd2, 1);
    access(0, 32'hFFFF_0000);
    expect_out("R8 area0 over area2", 8'h01, 1, 0, 2'd2, 1);
    access(0, 32'h7FFF_0000);
    expect_out("R2 mask bit15 ignored", 8'h00, 0, 1, 2'd0, 0);
    cfg(0, 3'd3, 32'h2003_0003);
    cfg(1, 3'd3, 32'h01);
    access(0, 32'h2000_0000);
    expect_out("R3 base bits under mask", 8'h08, 1, 0, 2'd0, 0);
    access(0, 32'h2004_0000);
    expect_out("R3 outside aligned area", 8'h00, 0, 1, 2'd0, 0);
  endtask

  task automatic t_disable;
    cfg(1, 3'd1, 32'h02);
    access(0, 32'h1000_0000);
    expect_out("R4 disabled area", 8'h00, 0, 1, 2'd0, 0);
  endtask

  task automatic t_width;
    cfg(1, 3'd3, 32'h0F);
    access(0, 32'h2001_0000);
    expect_out("R6 code3 as 32 big", 8'h08, 1, 0, 2'd2, 1);
  endtask

  task automatic t_area0;
    cfg(1, 3'd0, 32'h03);
    access(0, 32'hFFFF_8000);
    expect_out("R7 area0 forced big", 8'h01, 1, 0, 2'd1, 1);
  endtask

  task automatic t_overlap;
    cfg(0, 3'd4, 32'h2000_0003);
    cfg(1, 3'd4, 32'h05);
    access(0, 32'h2002_0000);
    expect_out("R8 lower area wins", 8'h08, 1, 0, 2'd2, 1);
    cfg(1, 3'd3, 32'h00);
    access(0, 32'h2002_0000);
    expect_out("R8 next area after disable", 8'h10, 1, 0, 2'd2, 0);
  endtask

  task automatic t_protect;
    cfg(1, 3'd4, 32'h15);
    access(1, 32'h2000_0000);
    expect_out("R5 write to read-only", 8'h00, 0, 0, 2'd0, 0);
    check("R9 fault set", {31'd0, fault_o}, 32'd1);
    access(0, 32'h2000_0000);
    expect_out("R5 read of read-only", 8'h10, 1, 0, 2'd2, 0);
    check("R9 fault sticky", {31'd0, fault_o}, 32'd1);
    cfg(0, 3'd5, 32'h0);
    check("R9 fault cleared by cfg", {31'd0, fault_o}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_i = 0; wr_i = 0; addr_i = '0;
    cfg_we_i = 0; cfg_kind_i = 0; cfg_sel_i = '0; cfg_wdata_i = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    t_reset;
    t_window;
    t_disable;
    t_width;
    t_area0;
    t_overlap;
    t_protect;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule